// File: doc/BRIEF.md
# Quad Serial Wiper Register Controller

This block holds the digital state of a four-channel programmable potentiometer. Each channel keeps a working wiper word that sets the analog tap, and a stored word that stands in for nonvolatile memory. Both are plain registers here. A host drives a chip select, a serial data line and a continuously running serial clock. Each frame names a channel and shifts in a new wiper word. The old word of that channel shifts out on the serial output in the same frame, so every write is also a read.

Words written while chip select stays high are temporary. Dropping chip select returns every channel to its stored word. A program strobe raised shortly after a frame ends makes the new word permanent. The ready output stays low while that commit is in progress.

Top module: `serial_wiper_ctrl`

## Requirements
- R1: Input data is sampled on the rising clock edge. While chip select is high and the block is idle, low bits are skipped. A high bit starts a frame. The next two bits give the channel index, low-order bit first. Eight data bits follow, least significant first.
- R2: On each falling edge in the data phase, the output presents the selected channel's current word, least significant bit first, one bit per data bit. The output is 0 outside the data phase and whenever chip select is low.
- R3: When a frame completes with chip select high, the selected channel's wiper takes the new word on the edge that samples the last data bit. The other three wipers do not change.
- R4: Shifting empties the selected wiper as it goes. If chip select falls before the last data bit, the channel's word is recovered from its stored copy, so a partial frame acts as a read that leaves the output unchanged.
- R5: On each rising edge with chip select low, all four wipers load their stored words.
- R6: A program strobe sampled high on either of the two rising edges after the last data bit is accepted. Ready then stays low for exactly BUSY_CYC sampled cycles. At the end of that time the new word is written to the stored copy of the selected channel.
- R7: If no strobe arrives in that two-edge window, the new word is dropped. A later strobe leaves ready high and the stored words unchanged.
- R8: Input bits in the two-edge window are ignored. The start bit of the next frame is accepted on the third rising edge after the last data bit.
- R9: While ready is low, serial input is ignored, the output stays 0 and no wiper changes.
- R10: After reset, every stored word and wiper equals RST_VAL, ready is high and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, running continuously |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| di | input | 1 | Serial data in |
| prog | input | 1 | Program strobe |
| dout | output | 1 | Serial data out |
| rdy | output | 1 | High when idle, low during a commit |
| wiper_o | output | NCH*DW | Wiper words, channel 0 in the low bits |

## Verification
The bench keeps the default width of eight bits, four channels and the two-edge commit window, and sets RST_VAL to 8'h5A. With those defaults, reset is not confused with an all-zero or all-one word. BUSY_CYC is set to 12, which is longer than one eleven-bit frame. A whole frame can then be sent during a commit, which shows that it is ignored and that the busy period has the exact length.

// File: rtl/swc_pkg.sv
package swc_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_ADDR,
      FR_DATA,
      FR_HOLD,
      FR_BUSY
   } fr_state_e;
endpackage

// File: rtl/swc_frame.sv
module swc_frame
   import swc_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int DW       = 8,
   parameter int BUSY_CYC = 16,
   parameter int HOLD_CYC = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs,
   input  logic                       di,
   input  logic                       prog,
   input  logic [DW-1:0]              cur_word,
   output logic [$clog2(NCH)-1:0]     sel,
   output logic                       shift_en,
   output logic                       commit_en,
   output logic [DW-1:0]              pend,
   output logic                       rdy,
   output logic                       data_phase
);
   localparam int AW   = $clog2(NCH);
   localparam int MAXC = (DW > HOLD_CYC) ? ((DW > NCH) ? DW : NCH)
                                         : ((HOLD_CYC > NCH) ? HOLD_CYC : NCH);
   localparam int CW   = $clog2(MAXC) + 1;
   localparam int BW   = $clog2(BUSY_CYC + 1);

   fr_state_e         st;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bcnt;
   logic [AW-1:0]     sel_q;
   logic [DW-1:0]     pend_q;

   logic last_data, last_addr, hold_end;
   assign last_data = (cnt == CW'(DW - 1));
   assign last_addr = (cnt == CW'(AW - 1));
   assign hold_end  = (cnt == CW'(HOLD_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FR_IDLE;
         cnt    <= '0;
         bcnt   <= '0;
         sel_q  <= '0;
         pend_q <= '0;
      end else if (st == FR_BUSY) begin
         if (bcnt == '0) begin
            st  <= FR_IDLE;
            cnt <= '0;
         end else begin
            bcnt <= bcnt - 1'b1;
         end
      end else if (!cs) begin
         st  <= FR_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            FR_IDLE: begin
               if (di) begin
                  st  <= FR_ADDR;
                  cnt <= '0;
               end
            end
            FR_ADDR: begin
               sel_q[cnt[AW-1:0]] <= di;
               if (last_addr) begin
                  st  <= FR_DATA;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_DATA: begin
               if (last_data) begin
                  st     <= FR_HOLD;
                  cnt    <= '0;
                  pend_q <= {di, cur_word[DW-1:1]};
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_HOLD: begin
               if (prog) begin
                  st   <= FR_BUSY;
                  bcnt <= BW'(BUSY_CYC - 1);
               end else if (hold_end) begin
                  st  <= FR_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               st  <= FR_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   assign sel        = sel_q;
   assign pend       = pend_q;
   assign shift_en   = (st == FR_DATA) && cs;
   assign data_phase = (st == FR_DATA);
   assign commit_en  = (st == FR_BUSY) && (bcnt == '0);
   assign rdy        = (st != FR_BUSY);

   // R6
   rdy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> ($past(prog) && $past(cs)));

   // R6
   commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> rdy);
endmodule

// File: rtl/swc_cell.sv
module swc_cell #(
   parameter int          DW      = 8,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          di,
   input  logic          shift,
   input  logic          commit,
   input  logic [DW-1:0] commit_val,
   output logic [DW-1:0] wiper,
   output logic [DW-1:0] stored
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stored <= RST_VAL;
      else if (commit) stored <= commit_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wiper <= RST_VAL;
      else if (!cs)   wiper <= stored;
      else if (shift) wiper <= {di, wiper[DW-1:1]};
   end

   // R5
   restore_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> (wiper == $past(stored)));

   // R7
   stored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(stored));
endmodule

// File: rtl/swc_bank.sv
module swc_bank #(
   parameter int            NCH     = 4,
   parameter int            DW      = 8,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs,
   input  logic                   di,
   input  logic                   rdy,
   input  logic [$clog2(NCH)-1:0] sel,
   input  logic                   shift_en,
   input  logic                   commit_en,
   input  logic [DW-1:0]          pend,
   output logic [DW-1:0]          cur_word,
   output logic [NCH*DW-1:0]      wiper_flat
);
   logic [DW-1:0]  wp_arr [NCH];
   logic [DW-1:0]  st_arr [NCH];
   logic [NCH-1:0] shift_vec;
   logic [NCH-1:0] commit_vec;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign shift_vec[g]  = shift_en  && (sel == g);
      assign commit_vec[g] = commit_en && (sel == g);

      swc_cell #(.DW(DW), .RST_VAL(RST_VAL)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .cs         (cs),
         .di         (di),
         .shift      (shift_vec[g]),
         .commit     (commit_vec[g]),
         .commit_val (pend),
         .wiper      (wp_arr[g]),
         .stored     (st_arr[g])
      );

      assign wiper_flat[g*DW +: DW] = wp_arr[g];
   end

   assign cur_word = wp_arr[sel];

   // R1
   single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(shift_vec));

   // R9
   busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && cs) |=> $stable(wiper_flat));
endmodule

// File: rtl/swc_sdo.sv
module swc_sdo (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic data_phase,
   input  logic lsb,
   output logic dout
);
   logic do_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) do_q <= 1'b0;
      else        do_q <= data_phase & cs & lsb;
   end

   assign dout = do_q & cs;

   // R2
   quiet_outside_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_phase |-> (dout == 1'b0));
endmodule

// File: rtl/serial_wiper_ctrl.sv
module serial_wiper_ctrl #(
   parameter int            NCH      = 4,
   parameter int            DW       = 8,
   parameter int            BUSY_CYC = 16,
   parameter int            HOLD_CYC = 2,
   parameter logic [DW-1:0] RST_VAL  = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              di,
   input  logic              prog,
   output logic              dout,
   output logic              rdy,
   output logic [NCH*DW-1:0] wiper_o
);
   localparam int AW = $clog2(NCH);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (BUSY_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
      $error("BUSY_CYC and HOLD_CYC must be at least 1");
   end

   logic [AW-1:0] sel;
   logic          shift_en, commit_en, data_phase;
   logic [DW-1:0] pend, cur_word;

   swc_frame #(
      .NCH(NCH), .DW(DW), .BUSY_CYC(BUSY_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .di         (di),
      .prog       (prog),
      .cur_word   (cur_word),
      .sel        (sel),
      .shift_en   (shift_en),
      .commit_en  (commit_en),
      .pend       (pend),
      .rdy        (rdy),
      .data_phase (data_phase)
   );

   swc_bank #(.NCH(NCH), .DW(DW), .RST_VAL(RST_VAL)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .di         (di),
      .rdy        (rdy),
      .sel        (sel),
      .shift_en   (shift_en),
      .commit_en  (commit_en),
      .pend       (pend),
      .cur_word   (cur_word),
      .wiper_flat (wiper_o)
   );

   swc_sdo u_sdo (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .data_phase (data_phase),
      .lsb        (cur_word[0]),
      .dout       (dout)
   );
endmodule

// File: tb/serial_wiper_ctrl_tb.sv
module serial_wiper_ctrl_tb;
   localparam int          NCH  = 4;
   localparam int          DW   = 8;
   localparam int          BUSY = 12;
   localparam logic [7:0]  DEF  = 8'h5A;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, di = 1'b0, prog = 1'b0;
   wire  dout, rdy;
   wire  [NCH*DW-1:0] wiper_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] m_nv [NCH];
   logic [7:0] m_wp [NCH];

   serial_wiper_ctrl #(
      .NCH(NCH), .DW(DW), .BUSY_CYC(BUSY), .HOLD_CYC(2), .RST_VAL(DEF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .prog(prog),
      .dout(dout), .rdy(rdy), .wiper_o(wiper_o)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] wp(input int c);
      return wiper_o[c*DW +: DW];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NCH; c++) chk(req, wp(c), m_wp[c]);
   endtask

   task automatic ensure_cs();
      if (!cs) begin
         step();
         cs = 1'b1;
      end
   endtask

   task automatic send_head(input int ch);
      step(); chk("R2 idle", dout, 0); di = 1'b1;
      step(); chk("R2 addr", dout, 0); di = ch[0];
      step(); di = ch[1];
   endtask

   task automatic send_data(input int ch, input logic [7:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         step();
         chk("R2 readback", dout, m_wp[ch][k]);
         di = v[k];
      end
   endtask

   task automatic cs_drop();
      step(); cs = 1'b0; di = 1'b0;
      chk("R2 cs low", dout, 0);
      step();
      for (int c = 0; c < NCH; c++) begin
         chk("R5 restore", wp(c), m_nv[c]);
         m_wp[c] = m_nv[c];
      end
   endtask

   // slot 0/1: strobe on first/second window edge, 2: no strobe
   task automatic do_write(input int ch, input logic [7:0] v, input int slot);
      int n;
      send_head(ch);
      send_data(ch, v, 8);
      m_wp[ch] = v;
      step(); di = 1'b0;
      check_all("R3 temp write");
      prog = (slot == 0);
      step(); prog = (slot == 1);
      if (slot == 1) begin
         step(); prog = 1'b0;
      end
      if (slot == 2) begin
         step(); prog = 1'b1;
         step(); prog = 1'b0;
         chk("R7 late strobe", rdy, 1);
      end else begin
         n = 0;
         while (rdy === 1'b0 && n < 100) begin
            n++;
            step();
         end
         chk("R6 busy length", n, BUSY);
         m_nv[ch] = v;
      end
   endtask

   task automatic read_only(input int ch, input int n);
      logic [7:0] junk;
      junk = 8'($urandom);
      send_head(ch);
      send_data(ch, junk, n);
      step(); cs = 1'b0; di = 1'b0;
      step();
      chk("R4 read-only restore", wp(ch), m_nv[ch]);
      for (int c = 0; c < NCH; c++) m_wp[c] = m_nv[c];
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++) begin
         m_nv[c] = DEF;
         m_wp[c] = DEF;
      end
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R10 reset state
      chk("R10 rdy", rdy, 1);
      chk("R10 dout", dout, 0);
      check_all("R10 wiper");

      // R1/R3: leading zeros skipped, then write channel 3
      cs = 1'b1;
      step(); step();
      do_write(3, 8'hC3, 2);
      // R6: commit on the first window edge
      do_write(1, 8'h96, 0);
      cs_drop();
      chk("R6 stored ch1", wp(1), 8'h96);
      chk("R7 dropped ch3", wp(3), DEF);

      // R6: commit on the second window edge
      ensure_cs();
      do_write(2, 8'h0F, 1);
      cs_drop();

      // R8: ones in the window ignored, next frame starts on the third edge
      ensure_cs();
      send_head(0); send_data(0, 8'h81, 8); m_wp[0] = 8'h81;
      step(); di = 1'b1;
      step(); di = 1'b1;
      send_head(2); send_data(2, 8'h3C, 8); m_wp[2] = 8'h3C;
      step(); di = 1'b0;
      chk("R8 chan0", wp(0), 8'h81);
      chk("R8 chan2", wp(2), 8'h3C);
      step(); step();
      cs_drop();

      // R9: a whole frame during busy is ignored
      ensure_cs();
      send_head(0); send_data(0, 8'hE7, 8); m_wp[0] = 8'hE7;
      step(); di = 1'b0; prog = 1'b1;
      begin
         logic [10:0] bits;
         bits = {8'h55, 2'b10, 1'b1};
         for (int k = 0; k < 11; k++) begin
            step(); prog = 1'b0;
            chk("R9 dout quiet", dout, 0);
            di = bits[k];
         end
      end
      step(); di = 1'b0;
      chk("R9 chan1 unchanged", wp(1), m_wp[1]);
      while (rdy === 1'b0) step();
      m_nv[0] = 8'hE7;
      cs_drop();

      // R4: read-only cycles
      ensure_cs();
      read_only(1, 8'd5);
      ensure_cs();
      read_only(2, 0);

      // random mix
      for (int it = 0; it < 120; it++) begin
         int op, ch;
         logic [7:0] v;
         op = int'($urandom % 6);
         ch = int'($urandom % NCH);
         v  = 8'($urandom);
         ensure_cs();
         case (op)
            0, 1: do_write(ch, v, 2);
            2:    do_write(ch, v, 0);
            3:    do_write(ch, v, 1);
            4:    read_only(ch, int'($urandom % 8));
            default: cs_drop();
         endcase
         if ($urandom % 3 == 0) cs_drop();
      end
      cs_drop();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule